// File: doc/BRIEF.md
# Addressed SPI Command Front End

This block is the serial front end of a control device that shares an SPI bus (mode 0) with up to three identical devices. All bus pins are brought into the system clock domain through two-flop synchronisers. The block then finds the serial clock edges and works through each transfer as a short sequence of bytes. The first byte after chip select falls is an identification byte. It is accepted only when its upper nibble carries the fixed device-type code, its two middle bits are zero, and its two low bits equal the strap pins. If the identification byte does not match, the block ignores the rest of the transfer.

Once the device is addressed, the second byte is decoded as a command. It gives a 4-bit opcode, a 2-bit data-register index and a 2-bit channel index, and these are reported with a single-cycle strobe. Every later complete byte is reported on a data-valid strobe. While that happens, a byte supplied by the register logic behind the block is shifted out on the serial output. Serial input is captured on rising SCK and serial output changes on falling SCK. A hold input, sampled only while SCK is low, freezes the sequence without losing its position.

Top module: `spi_cmd_frontend`

## Requirements
- R1: After reset, soEn, cmdStrobe and rxValid are low. No command is accepted until csN has been seen going from high to low after reset. A transfer on a select line that was already low at reset produces no strobe.
- R2: The identification byte is accepted when bits [7:4] equal 4'b0101, bits [3:2] equal 2'b00 and bits [1:0] equal strapAddr.
- R3: If the identification byte does not match, the rest of the transfer gives no cmdStrobe and no rxValid, and soEn stays low until csN rises.
- R4: After the eighth bit of the byte that follows an accepted identification byte, cmdStrobe is high for exactly one clock. At the same time cmdOp carries bits [7:4], cmdReg carries bits [3:2] and cmdCh carries bits [1:0].
- R5: siIn is sampled on rising SCK, most significant bit first. Each complete byte after the command byte sets rxValid high for exactly one clock, with the byte on rxByte. cmdStrobe and rxValid are never high together.
- R6: After the command byte, txByte is sent on soOut most significant bit first. soOut changes only after falling SCK edges, and the first bit appears at the falling edge that ends the command byte. soEn is high only in this data phase while selected and not held.
- R7: csN high abandons any partial byte or sequence. The first byte after the next falling edge of csN is again treated as an identification byte.
- R8: holdN is sampled only while SCK is low. While a hold is active, SCK edges are ignored and soEn is low. Bit position and phase are kept, so the transfer continues correctly once the hold is released.
- R9: If csN rises in the same clock as the SCK rising edge that would complete a data byte, the deselect wins and no rxValid is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sckIn | input | 1 | Serial clock from the bus master |
| csN | input | 1 | Chip select, active low |
| siIn | input | 1 | Serial data in |
| holdN | input | 1 | Pause request, active low |
| strapAddr | input | 2 | Board strap that sets the device address |
| txByte | input | 8 | Byte to send in the next byte slot |
| soOut | output | 1 | Serial data out value |
| soEn | output | 1 | Output enable for the serial data pad (low means high impedance) |
| cmdStrobe | output | 1 | One-cycle pulse when a command byte is decoded |
| cmdOp | output | 4 | Decoded opcode |
| cmdReg | output | 2 | Decoded data-register index |
| cmdCh | output | 2 | Decoded channel index |
| rxValid | output | 1 | One-cycle pulse when a data byte is complete |
| rxByte | output | 8 | Received data byte |

## Verification
A rising chip select and the SCK edge that completes a data byte can reach the control logic in the same system clock, because both pass through synchronisers of equal depth. The bench provokes this by switching csN and sckIn at the same instant on the eighth bit of a data byte. It judges the result at the ports: the command strobe of that transfer is counted, no data-valid strobe appears, and the next transfer decodes cleanly from its identification byte. A second overlap, a hold raised while a data bit is waiting on soOut, is judged by soEn falling and by the full byte reading back intact after release.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;

  typedef enum logic [2:0] {
    ST_WAIT   = 3'd0,
    ST_ID     = 3'd1,
    ST_INSTR  = 3'd2,
    ST_DATA   = 3'd3,
    ST_IGNORE = 3'd4
  } feState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftIn;
    logic shiftOut;
    logic txLoad;
    logic cmdLoad;
    logic rxLoad;
  } feCtl_t;

endpackage

// File: rtl/fe_sync.sv
module fe_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage[0] <= RST_VAL;
    else     stage[0] <= din;
  end

  for (genvar g = 1; g < STAGES; g++) begin : gStage
    always_ff @(posedge clk) begin
      if (rst) stage[g] <= RST_VAL;
      else     stage[g] <= stage[g-1];
    end
  end

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/fe_ctrl.sv
module fe_ctrl
  import spi_fe_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int TYPE_W = 4,
  parameter int ADDR_W = 2,
  parameter logic [TYPE_W-1:0] TYPE_CODE = 4'b0101,
  localparam int CNT_W = $clog2(BYTE_W),
  localparam int PAD_W = BYTE_W - TYPE_W - ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sckS,
  input  logic              csS,
  input  logic              holdS,
  input  logic [BYTE_W-1:0] byteNext,
  input  logic [ADDR_W-1:0] strapAddr,
  output feCtl_t            ctl,
  output feState_e          state,
  output logic              holdActive,
  output logic [CNT_W-1:0]  bitCnt,
  output logic              soEn
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic sckPrev, csPrev;
  logic sckRise, sckFall, csFall;
  logic edgesLive, inShiftPhase, riseEff, fallEff, byteDone, idOk;
  feState_e stateNext;

  assign sckRise = sckS & ~sckPrev;
  assign sckFall = ~sckS & sckPrev;
  assign csFall  = ~csS & csPrev;

  assign edgesLive    = ~csS & ~holdActive;
  assign inShiftPhase = (state == ST_ID) || (state == ST_INSTR) || (state == ST_DATA);
  assign riseEff      = sckRise & edgesLive & inShiftPhase;
  assign fallEff      = sckFall & edgesLive & (state == ST_DATA);
  assign byteDone     = riseEff & (bitCnt == LAST_BIT);
  assign idOk         = (byteNext == {TYPE_CODE, {PAD_W{1'b0}}, strapAddr});

  always_comb begin
    ctl          = '0;
    ctl.shiftIn  = riseEff;
    ctl.shiftOut = fallEff;
    ctl.cmdLoad  = byteDone & (state == ST_INSTR);
    ctl.rxLoad   = byteDone & (state == ST_DATA);
    ctl.txLoad   = ctl.cmdLoad | ctl.rxLoad;
  end

  always_comb begin
    stateNext = state;
    if (csS) begin
      stateNext = ST_WAIT;
    end else begin
      unique case (state)
        ST_WAIT:   if (csFall) stateNext = ST_ID;
        ST_ID:     if (byteDone) stateNext = idOk ? ST_INSTR : ST_IGNORE;
        ST_INSTR:  if (byteDone) stateNext = ST_DATA;
        default:   stateNext = state;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sckPrev    <= 1'b0;
      csPrev     <= 1'b0;
      state      <= ST_WAIT;
      holdActive <= 1'b0;
      bitCnt     <= '0;
    end else begin
      sckPrev <= sckS;
      csPrev  <= csS;
      state   <= stateNext;
      if (csS)        holdActive <= 1'b0;
      else if (!sckS) holdActive <= ~holdS;
      if (csS)                     bitCnt <= '0;
      else if (byteDone)           bitCnt <= '0;
      else if (riseEff)            bitCnt <= bitCnt + 1'b1;
    end
  end

  assign soEn = (state == ST_DATA) & ~csS & ~holdActive;
endmodule

// File: rtl/fe_datapath.sv
module fe_datapath
  import spi_fe_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int OPC_W = 4,
  parameter int REG_W = 2,
  parameter int CH_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  feCtl_t            ctl,
  input  logic              siS,
  input  logic [BYTE_W-1:0] txByte,
  output logic [BYTE_W-1:0] byteNext,
  output logic              cmdStrobe,
  output logic [OPC_W-1:0]  cmdOp,
  output logic [REG_W-1:0]  cmdReg,
  output logic [CH_W-1:0]   cmdCh,
  output logic              rxValid,
  output logic [BYTE_W-1:0] rxByte,
  output logic              soOut
);
  logic [BYTE_W-1:0] rxShift;
  logic [BYTE_W-1:0] txShift;

  assign byteNext = {rxShift[BYTE_W-2:0], siS};

  always_ff @(posedge clk) begin
    if (rst) begin
      rxShift   <= '0;
      txShift   <= '0;
      soOut     <= 1'b0;
      cmdStrobe <= 1'b0;
      cmdOp     <= '0;
      cmdReg    <= '0;
      cmdCh     <= '0;
      rxValid   <= 1'b0;
      rxByte    <= '0;
    end else begin
      cmdStrobe <= ctl.cmdLoad;
      rxValid   <= ctl.rxLoad;
      if (ctl.shiftIn) rxShift <= byteNext;
      if (ctl.cmdLoad) {cmdOp, cmdReg, cmdCh} <= byteNext;
      if (ctl.rxLoad)  rxByte <= byteNext;
      if (ctl.txLoad) begin
        txShift <= txByte;
      end else if (ctl.shiftOut) begin
        soOut   <= txShift[BYTE_W-1];
        txShift <= {txShift[BYTE_W-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/spi_cmd_frontend.sv
module spi_cmd_frontend
  import spi_fe_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int OPC_W = 4,
  parameter int REG_W = 2,
  parameter int CH_W = 2,
  parameter int ADDR_W = 2,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sckIn,
  input  logic              csN,
  input  logic              siIn,
  input  logic              holdN,
  input  logic [ADDR_W-1:0] strapAddr,
  input  logic [BYTE_W-1:0] txByte,
  output logic              soOut,
  output logic              soEn,
  output logic              cmdStrobe,
  output logic [OPC_W-1:0]  cmdOp,
  output logic [REG_W-1:0]  cmdReg,
  output logic [CH_W-1:0]   cmdCh,
  output logic              rxValid,
  output logic [BYTE_W-1:0] rxByte
);
  logic sckS, csS, siS, holdS;
  feCtl_t ctl;
  feState_e state;
  logic holdActive;
  logic [CNT_W-1:0] bitCnt;
  logic [BYTE_W-1:0] byteNext;

  // order: sck, cs, si, hold
  fe_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0001)) uSync (
    .clk (clk),
    .rst (rst),
    .din ({sckIn, csN, siIn, holdN}),
    .dout({sckS, csS, siS, holdS})
  );

  fe_ctrl #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) uCtrl (
    .clk       (clk),
    .rst       (rst),
    .sckS      (sckS),
    .csS       (csS),
    .holdS     (holdS),
    .byteNext  (byteNext),
    .strapAddr (strapAddr),
    .ctl       (ctl),
    .state     (state),
    .holdActive(holdActive),
    .bitCnt    (bitCnt),
    .soEn      (soEn)
  );

  fe_datapath #(.BYTE_W(BYTE_W), .OPC_W(OPC_W), .REG_W(REG_W), .CH_W(CH_W)) uData (
    .clk      (clk),
    .rst      (rst),
    .ctl      (ctl),
    .siS      (siS),
    .txByte   (txByte),
    .byteNext (byteNext),
    .cmdStrobe(cmdStrobe),
    .cmdOp    (cmdOp),
    .cmdReg   (cmdReg),
    .cmdCh    (cmdCh),
    .rxValid  (rxValid),
    .rxByte   (rxByte),
    .soOut    (soOut)
  );
endmodule

// File: rtl/spi_cmd_frontend_chk.sv
module spi_cmd_frontend_chk
  import spi_fe_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             soEn,
  input logic             soOut,
  input logic             cmdStrobe,
  input logic             rxValid,
  input logic             holdActive,
  input logic [CNT_W-1:0] bitCnt,
  input feState_e         state,
  input logic             shiftOut
);
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!soEn && !cmdStrobe && !rxValid)); // R1

  AST_REJECT_SILENT: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IGNORE) |-> (!soEn && !cmdStrobe && !rxValid)); // R3

  AST_CMD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    cmdStrobe |=> !cmdStrobe); // R4

  AST_RX_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rxValid |=> !rxValid); // R5

  AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(cmdStrobe && rxValid)); // R5

  AST_SO_ON_FALL_ONLY: assert property (@(posedge clk) disable iff (rst)
    (soEn && $past(soEn) && !$past(shiftOut)) |-> $stable(soOut)); // R6

  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (holdActive && $past(holdActive)) |-> $stable(bitCnt)); // R8
endmodule

bind spi_cmd_frontend spi_cmd_frontend_chk #(.CNT_W(CNT_W)) uChk (
  .clk       (clk),
  .rst       (rst),
  .soEn      (soEn),
  .soOut     (soOut),
  .cmdStrobe (cmdStrobe),
  .rxValid   (rxValid),
  .holdActive(holdActive),
  .bitCnt    (bitCnt),
  .state     (state),
  .shiftOut  (ctl.shiftOut)
);

// File: tb/sim_spi_cmd_frontend.sv
module sim_spi_cmd_frontend;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sckIn = 1'b0;
  logic csN = 1'b0;
  logic siIn = 1'b0;
  logic holdN = 1'b1;
  logic [1:0] strapAddr = 2'b10;
  logic [7:0] txByte = 8'h00;
  logic soOut, soEn, cmdStrobe, rxValid;
  logic [3:0] cmdOp;
  logic [1:0] cmdReg, cmdCh;
  logic [7:0] rxByte;

  always #2 clk = ~clk;

  spi_cmd_frontend u0 (
    .clk(clk), .rst(rst), .sckIn(sckIn), .csN(csN), .siIn(siIn), .holdN(holdN),
    .strapAddr(strapAddr), .txByte(txByte), .soOut(soOut), .soEn(soEn),
    .cmdStrobe(cmdStrobe), .cmdOp(cmdOp), .cmdReg(cmdReg), .cmdCh(cmdCh),
    .rxValid(rxValid), .rxByte(rxByte)
  );

  int nChecks = 0;
  int nFail = 0;
  int cmdCnt = 0;
  int rxCnt = 0;
  logic [7:0] lastCmd = 8'h00;
  logic [7:0] rxLog [32];
  logic soSeen = 1'b0;
  logic [7:0] rdByte = 8'h00;
  bit done = 1'b0;

  // accept, id, instr, data, tx
  localparam logic [32:0] VEC [6] = '{
    {1'b1, 8'h52, 8'hA6, 8'h5A, 8'hC3},
    {1'b0, 8'h51, 8'hA6, 8'h5A, 8'hC3},
    {1'b0, 8'h72, 8'h12, 8'h34, 8'h99},
    {1'b0, 8'h56, 8'h12, 8'h34, 8'h99},
    {1'b1, 8'h52, 8'h0F, 8'hFF, 8'h00},
    {1'b1, 8'h52, 8'hF0, 8'h00, 8'hFF}
  };

  always @(negedge clk) begin
    if (!rst) begin
      if (cmdStrobe) begin
        cmdCnt++;
        lastCmd = {cmdOp, cmdReg, cmdCh};
      end
      if (rxValid) begin
        rxLog[rxCnt[4:0]] = rxByte;
        rxCnt++;
      end
      if (soEn) soSeen = 1'b1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitHalf();
    repeat (8) @(posedge clk);
    #1;
  endtask

  task automatic sendBits(input logic [7:0] b, input int hi, input int lo);
    for (int i = hi; i >= lo; i--) begin
      siIn = b[i];
      waitHalf();
      rdByte[i] = soOut;
      sckIn = 1'b1;
      waitHalf();
      sckIn = 1'b0;
    end
  endtask

  task automatic junkClocks(input int n);
    siIn = 1'b1;
    for (int i = 0; i < n; i++) begin
      sckIn = 1'b1;
      waitHalf();
      sckIn = 1'b0;
      waitHalf();
    end
  endtask

  task automatic select();
    csN = 1'b0;
    waitHalf();
  endtask

  task automatic deselect();
    waitHalf();
    csN = 1'b1;
    waitHalf();
    waitHalf();
  endtask

  initial begin
    logic acc;
    logic [7:0] vId, vIns, vDat, vTx;
    int c0, r0;

    // R1: reset with select already low
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    waitHalf();
    check("R1 soEn after reset", soEn, 0);
    check("R1 cmdStrobe after reset", cmdStrobe, 0);
    check("R1 rxValid after reset", rxValid, 0);
    sendBits(8'h52, 7, 0);
    sendBits(8'h9B, 7, 0);
    sendBits(8'h77, 7, 0);
    waitHalf();
    check("R1 no command without select edge", cmdCnt, 0);
    check("R1 no data without select edge", rxCnt, 0);
    csN = 1'b1;
    waitHalf();
    waitHalf();

    // table of transfers (R2 R3 R4 R5 R6)
    for (int v = 0; v < 6; v++) begin
      {acc, vId, vIns, vDat, vTx} = VEC[v];
      txByte = vTx;
      c0 = cmdCnt;
      r0 = rxCnt;
      soSeen = 1'b0;
      select();
      sendBits(vId, 7, 0);
      sendBits(vIns, 7, 0);
      sendBits(vDat, 7, 0);
      deselect();
      if (acc) begin
        check("R2 R4 command count", cmdCnt - c0, 1);
        check("R4 command fields", lastCmd, vIns);
        check("R5 data count", rxCnt - r0, 1);
        check("R5 data byte", rxLog[r0[4:0]], vDat);
        check("R6 serial out byte", rdByte, vTx);
      end else begin
        check("R3 no command on mismatch", cmdCnt - c0, 0);
        check("R3 no data on mismatch", rxCnt - r0, 0);
        check("R3 output stays tri-stated", soSeen, 0);
      end
    end

    // R7: abandoned partial command byte
    c0 = cmdCnt;
    select();
    sendBits(8'h52, 7, 0);
    sendBits(8'hFF, 7, 4);
    deselect();
    check("R7 partial byte gives no command", cmdCnt - c0, 0);
    txByte = 8'h66;
    select();
    sendBits(8'h52, 7, 0);
    sendBits(8'h3D, 7, 0);
    sendBits(8'h81, 7, 0);
    deselect();
    check("R7 fresh sequence command count", cmdCnt - c0, 1);
    check("R7 fresh sequence fields", lastCmd, 8'h3D);

    // R8: hold in command byte and in data byte
    c0 = cmdCnt;
    r0 = rxCnt;
    txByte = 8'hA5;
    select();
    sendBits(8'h52, 7, 0);
    sendBits(8'h6B, 7, 5);
    holdN = 1'b0;
    waitHalf();
    junkClocks(3);
    holdN = 1'b1;
    waitHalf();
    sendBits(8'h6B, 4, 0);
    sendBits(8'h3C, 7, 4);
    holdN = 1'b0;
    waitHalf();
    check("R8 output released during hold", soEn, 0);
    junkClocks(5);
    holdN = 1'b1;
    waitHalf();
    check("R6 output driven after hold release", soEn, 1);
    sendBits(8'h3C, 3, 0);
    deselect();
    check("R8 command after hold", lastCmd, 8'h6B);
    check("R8 one data byte after hold", rxCnt - r0, 1);
    check("R8 data byte after hold", rxLog[r0[4:0]], 8'h3C);
    check("R8 serial out after hold", rdByte, 8'hA5);

    // R5: two data bytes in one transfer
    r0 = rxCnt;
    txByte = 8'h5A;
    select();
    sendBits(8'h52, 7, 0);
    sendBits(8'h21, 7, 0);
    sendBits(8'h11, 7, 0);
    check("R6 first slot out", rdByte, 8'h5A);
    sendBits(8'hEE, 7, 0);
    deselect();
    check("R5 two data strobes", rxCnt - r0, 2);
    check("R5 first data byte", rxLog[r0[4:0]], 8'h11);
    check("R5 second data byte", rxLog[(r0 + 1) % 32], 8'hEE);
    check("R6 second slot out", rdByte, 8'h5A);

    // R9: deselect together with final rising edge
    c0 = cmdCnt;
    r0 = rxCnt;
    select();
    sendBits(8'h52, 7, 0);
    sendBits(8'h44, 7, 0);
    sendBits(8'hC7, 7, 1);
    siIn = 1'b1;
    waitHalf();
    sckIn = 1'b1;
    csN = 1'b1;
    waitHalf();
    sckIn = 1'b0;
    waitHalf();
    waitHalf();
    check("R9 command still seen", cmdCnt - c0, 1);
    check("R9 no data strobe on deselect edge", rxCnt - r0, 0);
    r0 = rxCnt;
    select();
    sendBits(8'h52, 7, 0);
    sendBits(8'h9E, 7, 0);
    sendBits(8'h2B, 7, 0);
    deselect();
    check("R7 clean transfer after collision", lastCmd, 8'h9E);
    check("R7 data after collision", rxLog[r0[4:0]], 8'h2B);

    // R2: other strap value
    strapAddr = 2'b01;
    c0 = cmdCnt;
    select();
    sendBits(8'h51, 7, 0);
    sendBits(8'hC5, 7, 0);
    deselect();
    check("R2 strap 01 accepted", cmdCnt - c0, 1);
    check("R2 strap 01 fields", lastCmd, 8'hC5);
    c0 = cmdCnt;
    select();
    sendBits(8'h52, 7, 0);
    sendBits(8'hC5, 7, 0);
    deselect();
    check("R2 old strap now rejected", cmdCnt - c0, 0);

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end
endmodule